// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits beside a USB host controller's transaction engine. Each time a transaction finishes, the engine presents a result code together with the status fields read from the transfer descriptor: Active, Stalled, Babble, the retry countdown, the short-packet-detect flag and a flag saying the byte count is used up. One cycle later the block returns the updated fields for writeback. It also returns a retry flag that tells the scheduler to issue the transaction again in a later frame, and a flag that marks the transfer set as finished.

Events that need the host's attention are collected as pending flags while the frame runs. They move into the host-visible status bits only on the one-cycle end-of-frame strobe. Software clears status bits by writing ones to them. The interrupt line is the OR of every status bit that is set and enabled. The short-packet bit has its own enable input. The error bit always raises the interrupt.

Result codes are 0 success, 1 short packet, 2 babble, 3 STALL handshake, 4 data buffer overrun or underrun, 5 bit stuff error. Codes 6 and 7 are reserved. Status bit 0 is the completion (short-packet) bit and status bit 1 is the error bit. The same bit positions apply to the clear word.

Top module: `td_status_unit`

## Requirements
- R1: The write-back fields are valid (`wb_valid` high) in the cycle after `txn_valid` is high. `wb_valid` is low after a cycle without a transaction, and every output is low while reset is applied.
- R2: Code 0 leaves Stalled, Babble and the countdown unchanged. It clears Active only if the byte count is exhausted, and it raises no status event.
- R3: Code 1 clears Active and sets `wb_set_done`. It makes the completion bit pending only if short-packet-detect is set on the descriptor.
- R4: Code 2 clears Active, sets Stalled and Babble, keeps the countdown, and makes the error bit pending.
- R5: Code 3 clears Active, sets Stalled, keeps Babble and the countdown, and makes the error bit pending.
- R6: Codes 4 and 5 with a nonzero countdown decrement it by one. If the result is still nonzero, all other fields stay unchanged, no event is raised, and `wb_retry` equals the incoming Active.
- R7: When a code 4 or 5 decrement reaches zero, Active is cleared, Stalled is set, `wb_retry` is low, and the error bit becomes pending.
- R8: Codes 4 and 5 with a countdown of zero on entry leave every field unchanged, raise no event, and set `wb_retry` to the incoming Active.
- R9: The status bits take the pending flags only on the clock edge where `eof_strobe` is high. An event in that same cycle counts toward the next frame.
- R10: A `sts_clr_we` cycle clears each status bit whose `sts_clr_data` bit is one. If an end-of-frame set of the same bit happens in that cycle, the set wins.
- R11: `irq` is high exactly when the error bit is set, or when the completion bit is set and `short_ien` is high.
- R12: Codes 6 and 7 return the fields unchanged, raise no event, and leave `wb_retry` and `wb_set_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | A transaction result is presented |
| txn_code | input | 3 | Result code |
| td_active_in | input | 1 | Descriptor Active bit |
| td_stalled_in | input | 1 | Descriptor Stalled bit |
| td_babble_in | input | 1 | Descriptor Babble bit |
| td_cerr_in | input | 2 | Descriptor retry countdown |
| td_spd_in | input | 1 | Descriptor short-packet-detect flag |
| td_len_done_in | input | 1 | Descriptor byte count exhausted |
| eof_strobe | input | 1 | One-cycle end-of-frame pulse |
| sts_clr_we | input | 1 | Status clear write strobe |
| sts_clr_data | input | 2 | Write-one-to-clear mask for the status bits |
| short_ien | input | 1 | Interrupt enable for the completion bit |
| wb_valid | output | 1 | Write-back fields are valid |
| wb_active | output | 1 | Updated Active |
| wb_stalled | output | 1 | Updated Stalled |
| wb_babble | output | 1 | Updated Babble |
| wb_cerr | output | 2 | Updated retry countdown |
| wb_retry | output | 1 | Reissue the transaction in a later frame |
| wb_set_done | output | 1 | Transfer set finished early by a short packet |
| sts_usbint | output | 1 | Completion status bit |
| sts_usberr | output | 1 | Error status bit |
| irq | output | 1 | Hardware interrupt |

## Verification
The assertions check on every cycle that the write-back appears one cycle after a transaction. They also check the babble, stall and countdown updates against the descriptor inputs of the previous cycle, that a retry always comes with an active descriptor, and that the error bit rises only after an end-of-frame strobe and falls after a clear. Some behaviour only the bench scenarios can show: that events from a whole frame build up and reach status at the correct boundary, that an event arriving in the strobe cycle waits for the next frame, that set wins over clear in the same cycle, and how the enable gates the interrupt over long mixed sequences.

// File: rtl/td_status_pkg.sv
package td_status_pkg;

    parameter int unsigned CERR_W = 2;
    parameter int unsigned STS_W  = 2;
    localparam int unsigned STS_INT = 0;
    localparam int unsigned STS_ERR = 1;

    typedef enum logic [2:0] {
        TXN_OK       = 3'd0,
        TXN_SHORT    = 3'd1,
        TXN_BABBLE   = 3'd2,
        TXN_STALL    = 3'd3,
        TXN_DBUF     = 3'd4,
        TXN_BITSTUFF = 3'd5
    } txn_code_e;

    typedef struct packed {
        logic              active;
        logic              stalled;
        logic              babble;
        logic [CERR_W-1:0] cerr;
    } td_fields_t;

endpackage

// File: rtl/td_outcome_eval.sv
module td_outcome_eval
    import td_status_pkg::*;
(
    input  logic [2:0] code,
    input  td_fields_t fields_in,
    input  logic       spd,
    input  logic       len_done,
    output td_fields_t fields_out,
    output logic       retry,
    output logic       set_done,
    output logic       ev_int,
    output logic       ev_err
);

    logic [CERR_W-1:0] cerr_dec;

    always_comb begin
        fields_out = fields_in;
        retry      = 1'b0;
        set_done   = 1'b0;
        ev_int     = 1'b0;
        ev_err     = 1'b0;
        cerr_dec   = fields_in.cerr - CERR_W'(1);
        case (code)
            TXN_OK: begin
                if (len_done) fields_out.active = 1'b0;
            end
            TXN_SHORT: begin
                fields_out.active = 1'b0;
                set_done          = 1'b1;
                ev_int            = spd;
            end
            TXN_BABBLE: begin
                fields_out.active  = 1'b0;
                fields_out.stalled = 1'b1;
                fields_out.babble  = 1'b1;
                ev_err             = 1'b1;
            end
            TXN_STALL: begin
                fields_out.active  = 1'b0;
                fields_out.stalled = 1'b1;
                ev_err             = 1'b1;
            end
            TXN_DBUF, TXN_BITSTUFF: begin
                if (fields_in.cerr == '0) begin
                    retry = fields_in.active;
                end else begin
                    fields_out.cerr = cerr_dec;
                    if (cerr_dec == '0) begin
                        fields_out.active  = 1'b0;
                        fields_out.stalled = 1'b1;
                        ev_err             = 1'b1;
                    end else begin
                        retry = fields_in.active;
                    end
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/frame_status_accum.sv
module frame_status_accum
    import td_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] events,
    input  logic             eof,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    input  logic [STS_W-1:0] ien,
    output logic [STS_W-1:0] sts,
    output logic             irq
);

    typedef struct packed {
        logic [STS_W-1:0] pend;
        logic [STS_W-1:0] sts;
    } fs_t;

    fs_t fs_d, fs_q;
    logic [STS_W-1:0] clr_eff;

    always_comb begin
        fs_d      = fs_q;
        clr_eff   = clr_we ? clr_mask : '0;
        fs_d.pend = (eof ? '0 : fs_q.pend) | events;
        fs_d.sts  = (fs_q.sts & ~clr_eff) | (eof ? fs_q.pend : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign sts = fs_q.sts;
    assign irq = |(fs_q.sts & ien);

endmodule

// File: rtl/td_status_unit.sv
module td_status_unit
    import td_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [2:0]        txn_code,
    input  logic              td_active_in,
    input  logic              td_stalled_in,
    input  logic              td_babble_in,
    input  logic [CERR_W-1:0] td_cerr_in,
    input  logic              td_spd_in,
    input  logic              td_len_done_in,
    input  logic              eof_strobe,
    input  logic              sts_clr_we,
    input  logic [STS_W-1:0]  sts_clr_data,
    input  logic              short_ien,
    output logic              wb_valid,
    output logic              wb_active,
    output logic              wb_stalled,
    output logic              wb_babble,
    output logic [CERR_W-1:0] wb_cerr,
    output logic              wb_retry,
    output logic              wb_set_done,
    output logic              sts_usbint,
    output logic              sts_usberr,
    output logic              irq
);

    typedef struct packed {
        logic       valid;
        td_fields_t fields;
        logic       retry;
        logic       done;
    } wb_t;

    td_fields_t       f_in, f_new;
    logic             e_retry, e_done, e_int, e_err;
    logic [STS_W-1:0] events, ien_vec, sts_vec;
    wb_t              wb_d, wb_q;

    assign f_in = '{active: td_active_in, stalled: td_stalled_in,
                    babble: td_babble_in, cerr: td_cerr_in};

    td_outcome_eval u_eval (
        .code       (txn_code),
        .fields_in  (f_in),
        .spd        (td_spd_in),
        .len_done   (td_len_done_in),
        .fields_out (f_new),
        .retry      (e_retry),
        .set_done   (e_done),
        .ev_int     (e_int),
        .ev_err     (e_err)
    );

    always_comb begin
        events           = '0;
        events[STS_INT]  = txn_valid & e_int;
        events[STS_ERR]  = txn_valid & e_err;
        ien_vec          = '0;
        ien_vec[STS_INT] = short_ien;
        ien_vec[STS_ERR] = 1'b1;
    end

    frame_status_accum u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .eof      (eof_strobe),
        .clr_we   (sts_clr_we),
        .clr_mask (sts_clr_data),
        .ien      (ien_vec),
        .sts      (sts_vec),
        .irq      (irq)
    );

    always_comb begin
        wb_d = '0;
        if (txn_valid) begin
            wb_d.valid  = 1'b1;
            wb_d.fields = f_new;
            wb_d.retry  = e_retry;
            wb_d.done   = e_done;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid    = wb_q.valid;
    assign wb_active   = wb_q.fields.active;
    assign wb_stalled  = wb_q.fields.stalled;
    assign wb_babble   = wb_q.fields.babble;
    assign wb_cerr     = wb_q.fields.cerr;
    assign wb_retry    = wb_q.retry;
    assign wb_set_done = wb_q.done;
    assign sts_usbint  = sts_vec[STS_INT];
    assign sts_usberr  = sts_vec[STS_ERR];

endmodule

// File: rtl/td_status_chk.sv
module td_status_chk
    import td_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              txn_valid,
    input logic [2:0]        txn_code,
    input logic [CERR_W-1:0] td_cerr_in,
    input logic              td_babble_in,
    input logic              eof_strobe,
    input logic              sts_clr_we,
    input logic [STS_W-1:0]  sts_clr_data,
    input logic              wb_valid,
    input logic              wb_active,
    input logic              wb_stalled,
    input logic              wb_babble,
    input logic [CERR_W-1:0] wb_cerr,
    input logic              wb_retry,
    input logic              wb_set_done,
    input logic              sts_usberr
);

    AST_WB_FOLLOWS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> wb_valid); // R1

    AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !wb_valid); // R1

    AST_BABBLE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_code == 3'd2) |=>
        (!wb_active && wb_stalled && wb_babble && wb_cerr == $past(td_cerr_in))); // R4

    AST_STALL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_code == 3'd3) |=>
        (!wb_active && wb_stalled && wb_babble == $past(td_babble_in)
         && wb_cerr == $past(td_cerr_in))); // R5

    AST_CERR_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (txn_code == 3'd4 || txn_code == 3'd5) && td_cerr_in != '0) |=>
        (wb_cerr == $past(td_cerr_in) - CERR_W'(1))); // R6

    AST_CERR_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (txn_code == 3'd4 || txn_code == 3'd5) && td_cerr_in == CERR_W'(1)) |=>
        (!wb_active && wb_stalled && !wb_retry)); // R7

    AST_CERR_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (txn_code == 3'd4 || txn_code == 3'd5) && td_cerr_in == '0) |=>
        (wb_cerr == '0 && wb_retry == wb_active)); // R8

    AST_RETRY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_retry |-> (wb_valid && wb_active)); // R6

    AST_ERR_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_usberr) |-> $past(eof_strobe)); // R9

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr_we && sts_clr_data[STS_ERR] && !eof_strobe) |=> !sts_usberr); // R10

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_code[2:1] == 2'b11) |=> (!wb_retry && !wb_set_done)); // R12

endmodule

bind td_status_unit td_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_valid    (txn_valid),
    .txn_code     (txn_code),
    .td_cerr_in   (td_cerr_in),
    .td_babble_in (td_babble_in),
    .eof_strobe   (eof_strobe),
    .sts_clr_we   (sts_clr_we),
    .sts_clr_data (sts_clr_data),
    .wb_valid     (wb_valid),
    .wb_active    (wb_active),
    .wb_stalled   (wb_stalled),
    .wb_babble    (wb_babble),
    .wb_cerr      (wb_cerr),
    .wb_retry     (wb_retry),
    .wb_set_done  (wb_set_done),
    .sts_usberr   (sts_usberr)
);

// File: tb/td_status_unit_test.sv
`timescale 1ns/1ps
module td_status_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid = 1'b0;
    logic [2:0] txn_code = '0;
    logic       td_active_in = 1'b0, td_stalled_in = 1'b0, td_babble_in = 1'b0;
    logic [1:0] td_cerr_in = '0;
    logic       td_spd_in = 1'b0, td_len_done_in = 1'b0;
    logic       eof_strobe = 1'b0, sts_clr_we = 1'b0, short_ien = 1'b0;
    logic [1:0] sts_clr_data = '0;
    logic       wb_valid, wb_active, wb_stalled, wb_babble, wb_retry, wb_set_done;
    logic [1:0] wb_cerr;
    logic       sts_usbint, sts_usberr, irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    td_status_unit uut (.*);

    // reference model state
    int    m_valid = 0, m_active = 0, m_stalled = 0, m_babble = 0, m_cerr = 0;
    int    m_retry = 0, m_done = 0;
    int    m_pend_int = 0, m_pend_err = 0, m_int = 0, m_err = 0;
    string m_tag = "R1";

    always @(posedge clk) begin
        int ev_i, ev_e, clr_i, clr_e;
        ev_i = 0; ev_e = 0;
        if (!rst_n) begin
            m_valid = 0; m_active = 0; m_stalled = 0; m_babble = 0; m_cerr = 0;
            m_retry = 0; m_done = 0; m_pend_int = 0; m_pend_err = 0;
            m_int = 0; m_err = 0; m_tag = "R1 reset";
        end else begin
            clr_i = (sts_clr_we && sts_clr_data[0]) ? 1 : 0;
            clr_e = (sts_clr_we && sts_clr_data[1]) ? 1 : 0;
            m_valid = txn_valid; m_retry = 0; m_done = 0;
            m_active = td_active_in; m_stalled = td_stalled_in;
            m_babble = td_babble_in; m_cerr = td_cerr_in;
            m_tag = "R1";
            if (txn_valid) begin
                case (txn_code)
                    0: begin m_tag = "R2"; if (td_len_done_in) m_active = 0; end
                    1: begin m_tag = "R3"; m_active = 0; m_done = 1; ev_i = td_spd_in; end
                    2: begin m_tag = "R4"; m_active = 0; m_stalled = 1; m_babble = 1; ev_e = 1; end
                    3: begin m_tag = "R5"; m_active = 0; m_stalled = 1; ev_e = 1; end
                    4, 5: begin
                        if (td_cerr_in == 0) begin
                            m_tag = "R8"; m_retry = td_active_in;
                        end else if (td_cerr_in == 1) begin
                            m_tag = "R7"; m_cerr = 0; m_active = 0; m_stalled = 1; ev_e = 1;
                        end else begin
                            m_tag = "R6"; m_cerr = td_cerr_in - 1; m_retry = td_active_in;
                        end
                    end
                    default: m_tag = "R12";
                endcase
            end else begin
                m_active = 0; m_stalled = 0; m_babble = 0; m_cerr = 0;
            end
            m_int = (m_int && !clr_i) || (eof_strobe && m_pend_int);
            m_err = (m_err && !clr_e) || (eof_strobe && m_pend_err);
            m_pend_int = (eof_strobe ? 0 : m_pend_int) | ev_i;
            m_pend_err = (eof_strobe ? 0 : m_pend_err) | ev_e;
        end
    end

    task automatic chk(string tag, string name, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(m_tag, "wb_valid", wb_valid, m_valid);
        if (m_valid != 0) begin
            chk(m_tag, "wb_active", wb_active, m_active);
            chk(m_tag, "wb_stalled", wb_stalled, m_stalled);
            chk(m_tag, "wb_babble", wb_babble, m_babble);
            chk(m_tag, "wb_cerr", wb_cerr, m_cerr);
            chk(m_tag, "wb_retry", wb_retry, m_retry);
            chk(m_tag, "wb_set_done", wb_set_done, m_done);
        end
        chk("R9/R10", "sts_usbint", sts_usbint, m_int);
        chk("R9/R10", "sts_usberr", sts_usberr, m_err);
        chk("R11", "irq", irq, (m_err != 0 || (m_int != 0 && short_ien)) ? 1 : 0);
    endtask

    task automatic drive(bit v, int code, bit a, bit s, bit b, int c, bit spd, bit ld,
                         bit eof, bit cwe, int cd);
        txn_valid = v; txn_code = 3'(code); td_active_in = a; td_stalled_in = s;
        td_babble_in = b; td_cerr_in = 2'(c); td_spd_in = spd; td_len_done_in = ld;
        eof_strobe = eof; sts_clr_we = cwe; sts_clr_data = 2'(cd);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                               // R1 reset state
        rst_n = 1'b1;
        idle(2);
        // R2 success without and with byte count exhausted
        drive(1, 0, 1, 0, 0, 3, 1, 0, 0, 0, 0);
        drive(1, 0, 1, 1, 1, 2, 0, 1, 0, 0, 0);
        // R3 short packet, detect set, then end of frame -> R9 status
        drive(1, 1, 1, 0, 0, 3, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, 0, 3, 0, 0, 0, 0, 0);
        idle(1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle(1);
        short_ien = 1'b1;                        // R11 enable gates interrupt
        idle(1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);  // R10 clear completion bit
        // R4 babble and R5 stall, reported at end of frame
        drive(1, 2, 1, 0, 0, 2, 0, 0, 0, 0, 0);
        drive(1, 3, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        idle(1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle(1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        // R6 countdown step, R7 expiry, R8 unlimited
        drive(1, 4, 1, 0, 0, 3, 0, 0, 0, 0, 0);
        drive(1, 5, 1, 0, 0, 2, 0, 0, 0, 0, 0);
        drive(1, 5, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        drive(1, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R12 reserved codes
        drive(1, 6, 1, 0, 1, 2, 1, 1, 0, 0, 0);
        drive(1, 7, 1, 1, 0, 3, 1, 0, 0, 0, 0);
        // R9 event in the strobe cycle waits a frame; R10 set beats clear
        drive(1, 1, 1, 0, 0, 3, 1, 0, 1, 1, 3);
        idle(2);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
        idle(2);
        short_ien = 1'b0;
        idle(1);
        // mixed random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 99) == 0) short_ien = ~short_ien;
            drive($urandom_range(0, 9) < 6, $urandom_range(0, 7),
                  $urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                  $urandom_range(0, 14) == 0, $urandom_range(0, 9) == 0,
                  $urandom_range(0, 3));
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule